// File: doc/BRIEF.md
# Direct-Mapped Write-Through Data Cache

This block is a direct-mapped data cache placed between a processor load/store port and a slower main memory that moves one 32-bit word per transfer. It keeps 1024 lines, each holding four 32-bit words, one tag and one valid bit. A 32-bit byte address is split into a tag, a line index and a word select. A load that finds its line valid and its tag equal returns the word in the same cycle, with no stall and no memory traffic.

A load or store that misses holds the processor stalled. The cache first empties its write queue to memory, then reads the four words of the block in ascending order and installs data, tag and valid bit together. The held access then hits. Stores are write-through: the word goes into the cache line and, through a four-entry queue of address/data pairs, to memory. The processor only waits on a store when that queue is full. A store that misses installs the whole block before it merges its word, so a line never holds words of two different tags.

The memory side uses a valid/ready handshake. A read returns its data on `mem_rdata` in the same cycle that `mem_valid` and `mem_ready` are both high.

Top module: `dmc_wt_cache`

## Requirements
- R1: Address bits 31:14 are the tag, bits 13:4 the line index and bits 3:2 the word within the line. A hit returns the word that bits 3:2 select.
- R2: After reset every line is invalid, so the first access to any index raises `cpu_stall`. With no request pending, `cpu_stall` and `mem_valid` are low.
- R3: A load to a valid line with an equal tag keeps `cpu_stall` low, returns the word on `cpu_rdata` in the same cycle and causes no memory read.
- R4: A load to a valid line whose stored tag differs is a miss. It refills the line from the new address, and a later access with the old tag misses again.
- R5: A refill issues exactly four reads (`mem_we` low) to the block's word addresses, with bits 1:0 zero and the word field going 0, 1, 2, 3 in order, one word per handshake.
- R6: `cpu_stall` stays high from the cycle the miss is seen until the line is installed. The access then completes with the word fetched from memory.
- R7: A store hit writes the word into the line without stalling while the write queue has room. A later load of that address returns the stored value.
- R8: Every accepted store reaches memory as one write (`mem_we` high) with its byte address and data, in the order the stores were accepted.
- R9: A store miss first refills the whole block from memory and then merges the stored word. The other three words of the line hold memory's values.
- R10: The write queue holds four stores. A store that arrives while the queue is full stalls until an entry has drained, and is then accepted.
- R11: All queued stores are written to memory before the first refill read of a miss is issued.
- R12: While `mem_valid` is high and `mem_ready` is low, `mem_valid`, `mem_we`, `mem_addr` and `mem_wdata` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_req | input | 1 | Access request; held until `cpu_stall` is low at a clock edge |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | 32 | Byte address of the access |
| cpu_wdata | input | 32 | Store data |
| cpu_rdata | output | 32 | Load data, valid when `cpu_req` is high and `cpu_stall` is low |
| cpu_stall | output | 1 | Processor must hold its request |
| mem_valid | output | 1 | Memory transfer request |
| mem_ready | input | 1 | Memory accepts the transfer this cycle |
| mem_we | output | 1 | 1 = write transfer, 0 = read transfer |
| mem_addr | output | 32 | Word-aligned byte address of the transfer |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, sampled in the handshake cycle |

## Verification
The hardest state to reach from the ports is a miss that arrives while stores are still queued. To get there, the bench makes the memory model refuse every handshake for a while, queues several store hits, and then issues a store miss. Only then does it let the memory accept transfers. The recorded memory trace must show all the queued writes ahead of the four ordered refill reads, followed by the merged store. The same refusal of handshakes is used to fill the queue and force the fifth store to stall.

// File: rtl/dmc_pkg.sv
package dmc_pkg;

    localparam int ADDR_W     = 32;
    localparam int DATA_W     = 32;
    localparam int LINES      = 1024;
    localparam int WORDS      = 4;
    localparam int WBUF_DEPTH = 4;

    localparam int BYTE_W = $clog2(DATA_W / 8);
    localparam int WSEL_W = $clog2(WORDS);
    localparam int IDX_W  = $clog2(LINES);
    localparam int OFF_W  = BYTE_W + WSEL_W;
    localparam int TAG_W  = ADDR_W - IDX_W - OFF_W;
    localparam int LINE_W = WORDS * DATA_W;

    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [DATA_W-1:0] word_t;
    typedef logic [TAG_W-1:0]  tag_t;
    typedef logic [IDX_W-1:0]  idx_t;
    typedef logic [WSEL_W-1:0] wsel_t;
    typedef logic [LINE_W-1:0] line_t;

    typedef struct packed {
        tag_t               tag;
        idx_t               idx;
        wsel_t              wsel;
        logic [BYTE_W-1:0]  bsel;
    } addr_f_t;

    typedef struct packed {
        addr_t addr;
        word_t data;
    } wr_ent_t;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_DRAIN = 2'd1,
        ST_FILL  = 2'd2
    } fsm_t;

    function automatic addr_f_t split_addr(addr_t a);
        return addr_f_t'(a);
    endfunction

    function automatic addr_t word_addr(tag_t t, idx_t i, wsel_t w);
        addr_f_t f;
        f.tag  = t;
        f.idx  = i;
        f.wsel = w;
        f.bsel = '0;
        return addr_t'(f);
    endfunction

    function automatic word_t pick_word(line_t l, wsel_t w);
        return l[w*DATA_W +: DATA_W];
    endfunction

endpackage

// File: rtl/dmc_line_store.sv
module dmc_line_store
    import dmc_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  idx_t  rd_idx,
    output logic  rd_valid,
    output tag_t  rd_tag,
    output line_t rd_line,
    input  logic  inst_en,
    input  idx_t  inst_idx,
    input  tag_t  inst_tag,
    input  line_t inst_line,
    input  logic  wr_en,
    input  idx_t  wr_idx,
    input  wsel_t wr_wsel,
    input  word_t wr_data
);

    logic [LINES-1:0] valid_q;
    tag_t             tag_q  [LINES];
    line_t            data_q [LINES];

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= '0;
        end else if (inst_en) begin
            valid_q[inst_idx] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (inst_en) begin
            tag_q[inst_idx]  <= inst_tag;
            data_q[inst_idx] <= inst_line;
        end else if (wr_en) begin
            data_q[wr_idx][wr_wsel*DATA_W +: DATA_W] <= wr_data;
        end
    end

    assign rd_valid = valid_q[rd_idx];
    assign rd_tag   = tag_q[rd_idx];
    assign rd_line  = data_q[rd_idx];

    // R9
    no_merge_during_install_chk: assert property (@(posedge clk) disable iff (rst)
        !(inst_en && wr_en));

    // R6
    install_sets_valid_chk: assert property (@(posedge clk) disable iff (rst)
        inst_en |=> valid_q[$past(inst_idx)]);

endmodule

// File: rtl/dmc_write_fifo.sv
module dmc_write_fifo
    import dmc_pkg::*;
#(
    parameter int DEPTH = WBUF_DEPTH
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    push,
    input  wr_ent_t din,
    input  logic    pop,
    output wr_ent_t dout,
    output logic    empty,
    output logic    full
);

    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    wr_ent_t            ent_q [DEPTH];
    logic [PTR_W-1:0]   wr_ptr_q, rd_ptr_q;
    logic [CNT_W-1:0]   cnt_q;

    function automatic logic [PTR_W-1:0] ptr_inc(logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr_q <= '0;
            rd_ptr_q <= '0;
            cnt_q    <= '0;
        end else begin
            if (push) wr_ptr_q <= ptr_inc(wr_ptr_q);
            if (pop)  rd_ptr_q <= ptr_inc(rd_ptr_q);
            case ({push, pop})
                2'b10:   cnt_q <= cnt_q + 1'b1;
                2'b01:   cnt_q <= cnt_q - 1'b1;
                default: cnt_q <= cnt_q;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (push) ent_q[wr_ptr_q] <= din;
    end

    assign dout  = ent_q[rd_ptr_q];
    assign empty = (cnt_q == '0);
    assign full  = (cnt_q == CNT_W'(DEPTH));

    // R10
    no_push_when_full_chk: assert property (@(posedge clk) disable iff (rst)
        push |-> !full);

    // R8
    no_pop_when_empty_chk: assert property (@(posedge clk) disable iff (rst)
        pop |-> !empty);

endmodule

// File: rtl/dmc_refill_fsm.sv
module dmc_refill_fsm
    import dmc_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    req,
    input  logic    we,
    input  addr_f_t af,
    input  logic    hit,
    input  logic    wbuf_empty,
    input  logic    wbuf_full,
    input  logic    mem_ready,
    input  word_t   mem_rdata,
    output logic    acc_ok,
    output logic    stall,
    output logic    fill_active,
    output addr_t   fill_addr,
    output logic    inst_en,
    output idx_t    inst_idx,
    output tag_t    inst_tag,
    output line_t   inst_line
);

    fsm_t   state_q;
    tag_t   tag_q;
    idx_t   idx_q;
    wsel_t  cnt_q;
    word_t  buf_q [WORDS];
    logic   last_beat;

    assign fill_active = (state_q == ST_FILL);
    assign last_beat   = fill_active && mem_ready && (cnt_q == wsel_t'(WORDS - 1));
    assign acc_ok      = (state_q == ST_IDLE) && req && hit && !(we && wbuf_full);
    assign stall       = req && !acc_ok;
    assign fill_addr   = word_addr(tag_q, idx_q, cnt_q);
    assign inst_en     = last_beat;
    assign inst_idx    = idx_q;
    assign inst_tag    = tag_q;

    for (genvar w = 0; w < WORDS; w++) begin : g_line
        if (w == WORDS - 1) begin : g_last
            assign inst_line[w*DATA_W +: DATA_W] = mem_rdata;
        end else begin : g_held
            assign inst_line[w*DATA_W +: DATA_W] = buf_q[w];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            tag_q   <= '0;
            idx_q   <= '0;
            cnt_q   <= '0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (req && !hit) begin
                        tag_q   <= af.tag;
                        idx_q   <= af.idx;
                        state_q <= ST_DRAIN;
                    end
                end
                ST_DRAIN: begin
                    if (wbuf_empty) begin
                        cnt_q   <= '0;
                        state_q <= ST_FILL;
                    end
                end
                ST_FILL: begin
                    if (mem_ready) begin
                        cnt_q <= cnt_q + 1'b1;
                        if (last_beat) state_q <= ST_IDLE;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (fill_active && mem_ready) buf_q[cnt_q] <= mem_rdata;
    end

    // R11
    drain_before_fill_chk: assert property (@(posedge clk) disable iff (rst)
        (fill_active && $past(state_q) == ST_DRAIN) |-> wbuf_empty);

    // R6
    stall_while_busy_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q != ST_IDLE) |-> stall);

endmodule

// File: rtl/dmc_wt_cache.sv
module dmc_wt_cache
    import dmc_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        cpu_req,
    input  logic        cpu_we,
    input  logic [31:0] cpu_addr,
    input  logic [31:0] cpu_wdata,
    output logic [31:0] cpu_rdata,
    output logic        cpu_stall,
    output logic        mem_valid,
    input  logic        mem_ready,
    output logic        mem_we,
    output logic [31:0] mem_addr,
    output logic [31:0] mem_wdata,
    input  logic [31:0] mem_rdata
);

    addr_f_t af;
    logic    rd_valid, hit, acc_ok;
    tag_t    rd_tag;
    line_t   rd_line;
    logic    inst_en, fill_active;
    idx_t    inst_idx;
    tag_t    inst_tag;
    line_t   inst_line;
    addr_t   fill_addr;
    logic    st_take, wb_push, wb_pop, wb_empty, wb_full;
    wr_ent_t wb_in, wb_head;

    assign af  = split_addr(cpu_addr);
    assign hit = rd_valid && (rd_tag == af.tag);

    dmc_line_store u_store (
        .clk       (clk),
        .rst       (rst),
        .rd_idx    (af.idx),
        .rd_valid  (rd_valid),
        .rd_tag    (rd_tag),
        .rd_line   (rd_line),
        .inst_en   (inst_en),
        .inst_idx  (inst_idx),
        .inst_tag  (inst_tag),
        .inst_line (inst_line),
        .wr_en     (st_take),
        .wr_idx    (af.idx),
        .wr_wsel   (af.wsel),
        .wr_data   (cpu_wdata)
    );

    dmc_refill_fsm u_fsm (
        .clk         (clk),
        .rst         (rst),
        .req         (cpu_req),
        .we          (cpu_we),
        .af          (af),
        .hit         (hit),
        .wbuf_empty  (wb_empty),
        .wbuf_full   (wb_full),
        .mem_ready   (mem_ready),
        .mem_rdata   (mem_rdata),
        .acc_ok      (acc_ok),
        .stall       (cpu_stall),
        .fill_active (fill_active),
        .fill_addr   (fill_addr),
        .inst_en     (inst_en),
        .inst_idx    (inst_idx),
        .inst_tag    (inst_tag),
        .inst_line   (inst_line)
    );

    assign st_take    = acc_ok && cpu_we;
    assign wb_push    = st_take;
    assign wb_in.addr = word_addr(af.tag, af.idx, af.wsel);
    assign wb_in.data = cpu_wdata;
    assign wb_pop     = !fill_active && !wb_empty && mem_ready;

    dmc_write_fifo #(.DEPTH(WBUF_DEPTH)) u_wbuf (
        .clk   (clk),
        .rst   (rst),
        .push  (wb_push),
        .din   (wb_in),
        .pop   (wb_pop),
        .dout  (wb_head),
        .empty (wb_empty),
        .full  (wb_full)
    );

    assign cpu_rdata = pick_word(rd_line, af.wsel);
    assign mem_valid = fill_active || !wb_empty;
    assign mem_we    = !fill_active;
    assign mem_addr  = fill_active ? fill_addr : wb_head.addr;
    assign mem_wdata = wb_head.data;

    // R12
    hold_until_ready_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_valid && !mem_ready) |=>
            (mem_valid && $stable(mem_we) && $stable(mem_addr) && $stable(mem_wdata)));

    // R5
    refill_order_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_valid && mem_ready && !mem_we && mem_addr[OFF_W-1:BYTE_W] != '1) |=>
            (mem_valid && !mem_we &&
             mem_addr[OFF_W-1:BYTE_W] == wsel_t'($past(mem_addr[OFF_W-1:BYTE_W]) + 1'b1)));

    // R3
    hit_no_stall_chk: assert property (@(posedge clk) disable iff (rst)
        (cpu_req && !cpu_we && hit && !$past(inst_en) && !fill_active &&
         $past(!cpu_stall)) |-> !cpu_stall);

endmodule

// File: tb/test_dmc_wt_cache.sv
`timescale 1ns/100ps
module test_dmc_wt_cache;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cpu_req = 1'b0, cpu_we = 1'b0;
    logic [31:0] cpu_addr = '0, cpu_wdata = '0;
    logic [31:0] cpu_rdata;
    logic        cpu_stall;
    logic        mem_valid, mem_we;
    logic        mem_ready = 1'b0;
    logic [31:0] mem_addr, mem_wdata;
    logic [31:0] mem_rdata = '0;

    int n_chk = 0, n_fail = 0;
    bit mem_hold = 1'b0;
    bit ready_alt = 1'b0;
    int cyc = 0;

    logic [31:0] mem_model [logic [31:0]];
    logic        log_we   [$];
    logic [31:0] log_addr [$];
    logic [31:0] log_data [$];

    always #2.5 clk = ~clk;

    dmc_wt_cache i_dmc_wt_cache (
        .clk(clk), .rst(rst),
        .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cpu_rdata(cpu_rdata), .cpu_stall(cpu_stall),
        .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
    );

    function automatic logic [31:0] init_word(logic [31:0] a);
        return {a[15:0], ~a[15:0]} ^ 32'h1234_0000;
    endfunction

    function automatic logic [31:0] mem_read(logic [31:0] a);
        if (mem_model.exists(a)) return mem_model[a];
        return init_word(a);
    endfunction

    // memory model: ready and read data change only at the falling edge
    always @(negedge clk) begin
        cyc++;
        mem_ready = mem_hold ? 1'b0 : (ready_alt ? cyc[0] : 1'b1);
        mem_rdata = mem_read(mem_addr);
    end

    always @(posedge clk) begin
        if (!rst && mem_valid && mem_ready) begin
            log_we.push_back(mem_we);
            log_addr.push_back(mem_addr);
            log_data.push_back(mem_wdata);
            if (mem_we) mem_model[mem_addr] = mem_wdata;
        end
    end

    task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    task automatic cpu_access(input logic we, input logic [31:0] a, input logic [31:0] wd,
                              output logic [31:0] rd, output int stalls);
        @(negedge clk);
        cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = wd;
        #1;
        stalls = 0;
        while (cpu_stall) begin
            @(negedge clk); #1;
            stalls++;
        end
        rd = cpu_rdata;
        @(negedge clk);
        cpu_req = 1'b0; cpu_we = 1'b0;
    endtask

    task automatic wait_drain();
        @(negedge clk); #1;
        while (mem_valid) begin @(negedge clk); #1; end
        @(negedge clk);
    endtask

    task automatic t_reset();
        @(negedge clk); #1;
        chk(cpu_stall == 1'b0, "R2 idle stall after reset", cpu_stall, 0);
        chk(mem_valid == 1'b0, "R2 idle mem_valid after reset", mem_valid, 0);
    endtask

    task automatic t_cold_miss();
        logic [31:0] d; int s; int m;
        m = log_addr.size();
        cpu_access(1'b0, 32'h0000_0014, '0, d, s);
        chk(s > 0, "R2 first access misses", s, 1);
        chk(s >= 4, "R6 stall covers refill", s, 4);
        chk(d == init_word(32'h14), "R6 miss returns fetched word", d, init_word(32'h14));
        chk(log_addr.size() - m == 4, "R5 four refill reads", log_addr.size() - m, 4);
        for (int i = 0; i < 4; i++) begin
            if (m + i < log_addr.size()) begin
                chk(log_we[m+i] == 1'b0, "R5 refill is read", log_we[m+i], 0);
                chk(log_addr[m+i] == 32'h10 + 4*i, "R5 refill order", log_addr[m+i], 32'h10 + 4*i);
            end
        end
    endtask

    task automatic t_hits();
        logic [31:0] d; int s; int m;
        m = log_addr.size();
        for (int w = 0; w < 4; w++) begin
            cpu_access(1'b0, 32'h10 + 4*w + (w == 2 ? 1 : 0), '0, d, s);
            chk(s == 0, "R3 hit has no stall", s, 0);
            chk(d == init_word(32'h10 + 4*w), "R1 word select on hit", d, init_word(32'h10 + 4*w));
        end
        chk(log_addr.size() == m, "R3 hit makes no memory access", log_addr.size() - m, 0);
    endtask

    task automatic t_conflict();
        logic [31:0] d; int s;
        cpu_access(1'b0, 32'h0000_8014, '0, d, s);
        chk(s > 0, "R4 tag mismatch misses", s, 1);
        chk(d == init_word(32'h8014), "R4 new tag data", d, init_word(32'h8014));
        cpu_access(1'b0, 32'h0000_8018, '0, d, s);
        chk(s == 0 && d == init_word(32'h8018), "R1 new line hits", d, init_word(32'h8018));
        cpu_access(1'b0, 32'h0000_0014, '0, d, s);
        chk(s > 0, "R4 old tag misses again", s, 1);
        chk(d == init_word(32'h14), "R4 old tag data", d, init_word(32'h14));
    endtask

    task automatic t_store_hit();
        logic [31:0] d; int s; int m;
        m = log_addr.size();
        cpu_access(1'b1, 32'h0000_0018, 32'hDEAD_BEEF, d, s);
        chk(s == 0, "R7 store hit no stall", s, 0);
        cpu_access(1'b0, 32'h0000_0018, '0, d, s);
        chk(s == 0 && d == 32'hDEAD_BEEF, "R7 load sees stored word", d, 32'hDEAD_BEEF);
        wait_drain();
        chk(log_addr.size() - m == 1, "R8 one write", log_addr.size() - m, 1);
        if (log_addr.size() > m) begin
            chk(log_we[m] == 1'b1 && log_addr[m] == 32'h18, "R8 write address", log_addr[m], 32'h18);
            chk(log_data[m] == 32'hDEAD_BEEF, "R8 write data", log_data[m], 32'hDEAD_BEEF);
        end
    endtask

    task automatic t_store_miss();
        logic [31:0] d; int s; int m;
        logic [31:0] ea [7];
        logic        ew [7];
        wait_drain();
        mem_hold = 1'b1;
        @(negedge clk);
        m = log_addr.size();
        cpu_access(1'b1, 32'h10, 32'hAAAA_0001, d, s);
        chk(s == 0, "R7 queued store hit", s, 0);
        cpu_access(1'b1, 32'h14, 32'hAAAA_0002, d, s);
        chk(s == 0, "R7 queued store hit", s, 0);
        fork
            cpu_access(1'b1, 32'h200, 32'hBBBB_0003, d, s);
            begin repeat (6) @(negedge clk); mem_hold = 1'b0; end
        join
        chk(s >= 6, "R9 store miss stalls during refill", s, 6);
        wait_drain();
        ea = '{32'h10, 32'h14, 32'h200, 32'h204, 32'h208, 32'h20C, 32'h200};
        ew = '{1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1};
        chk(log_addr.size() - m == 7, "R11 trace length", log_addr.size() - m, 7);
        for (int i = 0; i < 7; i++) begin
            if (m + i < log_addr.size())
                chk(log_addr[m+i] == ea[i] && log_we[m+i] == ew[i],
                    "R11 writes drain before refill", log_addr[m+i], ea[i]);
        end
        cpu_access(1'b0, 32'h200, '0, d, s);
        chk(s == 0 && d == 32'hBBBB_0003, "R9 merged store word", d, 32'hBBBB_0003);
        cpu_access(1'b0, 32'h204, '0, d, s);
        chk(s == 0 && d == init_word(32'h204), "R9 neighbour from memory", d, init_word(32'h204));
    endtask

    task automatic t_wbuf_full();
        logic [31:0] d; int s; int m;
        wait_drain();
        mem_hold = 1'b1;
        @(negedge clk);
        m = log_addr.size();
        for (int i = 0; i < 4; i++) begin
            cpu_access(1'b1, 32'h10 + 4*i, 32'hC000_0000 + i, d, s);
            chk(s == 0, "R10 store accepted while room", s, 0);
        end
        fork
            cpu_access(1'b1, 32'h10, 32'hC000_0004, d, s);
            begin repeat (5) @(negedge clk); mem_hold = 1'b0; end
        join
        chk(s >= 4, "R10 fifth store stalls on full queue", s, 4);
        wait_drain();
        chk(log_addr.size() - m == 5, "R8 five writes", log_addr.size() - m, 5);
        for (int i = 0; i < 5; i++) begin
            if (m + i < log_addr.size())
                chk(log_we[m+i] && log_data[m+i] == 32'hC000_0000 + i,
                    "R8 write order", log_data[m+i], 32'hC000_0000 + i);
        end
        cpu_access(1'b0, 32'h10, '0, d, s);
        chk(d == 32'hC000_0004, "R10 last store in cache", d, 32'hC000_0004);
    endtask

    task automatic t_slow_memory();
        logic [31:0] d; int s;
        ready_alt = 1'b1;
        cpu_access(1'b0, 32'h0001_3FF8, '0, d, s);
        chk(s > 0 && d == init_word(32'h0001_3FF8), "R12 refill with gaps", d, init_word(32'h0001_3FF8));
        cpu_access(1'b0, 32'h0001_3FF0, '0, d, s);
        chk(s == 0 && d == init_word(32'h0001_3FF0), "R1 last index line", d, init_word(32'h0001_3FF0));
        ready_alt = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_cold_miss();
        t_hits();
        t_conflict();
        t_store_hit();
        t_store_miss();
        t_wbuf_full();
        t_slow_memory();
        summary();
        $finish;
    end

endmodule